// File: doc/BRIEF.md
# Interrupt Pin Service and MSI Generator

This block sits between a bank of external interrupt inputs and the fabric that carries message-signalled interrupts to processors. Every clock it samples the inputs and keeps a pending bit per pin. It looks up each pin's routing entry, which a separate redirection-table block supplies, and turns each deliverable request into one 32-bit address and 32-bit data write. The write is offered on a valid/ready interface. Input 0 is a legacy timer line that is steered onto pin 2.

Edge-mode pins fire once per rising edge. A rising edge that arrives while the pin is masked is thrown away. Level-mode pins keep their pending bit equal to the input level. A level pin is sent only while the table reports its remote-IRR flag as clear. On each level delivery the block pulses a request to set that flag. When the flag is later cleared by an end-of-interrupt, a line that is still high is sent again. A line that has dropped by then is not.

A small state machine drives the sending. It has two states: `ST_IDLE` (nothing offered) and `ST_ISSUE` (a message is held on the output).
- The launch transition, `ST_IDLE` to `ST_ISSUE`, is taken when any pin is deliverable. It loads the lowest such pin.
- The chain transition, `ST_ISSUE` to `ST_ISSUE`, is taken on an accepted write when a deliverable pin with a higher index exists. It loads that pin.
- The finish transition, `ST_ISSUE` to `ST_IDLE`, is taken on an accepted write when no higher pin is deliverable.

Top module: `irq_msi_gen`

## Requirements
- R1: A high level on input 0 is treated as a request on pin 2 (pin 2 requests when input 0 or input 2 is high). Pin 0 never produces a message.
- R2: For a level-mode pin whose remote-IRR flag is clear, a high input produces one message. While that message is accepted, `remote_irr_set` has exactly the bit of that pin high.
- R3: A level-mode pin whose remote-IRR flag is set produces no message, and its request stays pending. After the flag is cleared, a pin whose input is still high is sent again.
- R4: For a level-mode pin, a low input clears the pending request. A line that dropped before its remote-IRR flag was cleared produces no message after the clear.
- R5: An unmasked edge-mode pin produces exactly one message per rising edge. An input held high does not trigger again.
- R6: A rising edge on an edge-mode pin that is masked at that time is discarded. Unmasking the pin afterwards produces no message.
- R7: Requests pending at the same time are sent in ascending pin order. With `msi_ready` high they go out on consecutive clocks.
- R8: While `msi_valid` is high and `msi_ready` is low, `msi_valid`, `msi_addr` and `msi_data` hold their values.
- R9: `msi_addr` = 0xFEE00000 OR (destination << 4) OR (destination-mode << 2). The 16-bit destination field occupies bits 19:4 and the destination-mode bit occupies bit 2.
- R10: `msi_data` carries the vector in bits 7:0, the delivery mode in bits 10:8 and the trigger mode in bit 15 (1 = level). All other bits are 0.
- R11: From an idle block, an input that is high at clock edge k gives `msi_valid` high after edge k+2.
- R12: After reset, `msi_valid` and `remote_irr_set` are low and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_PINS | Interrupt input levels |
| rte_mask | input | NUM_PINS | Per-pin mask from the table |
| rte_level | input | NUM_PINS | Per-pin trigger mode, 1 = level |
| rte_remote_irr | input | NUM_PINS | Per-pin remote-IRR flag from the table |
| rte_vector | input | 8*NUM_PINS | Per-pin vector, pin p at [8p+7:8p] |
| rte_deliv | input | 3*NUM_PINS | Per-pin delivery mode, pin p at [3p+2:3p] |
| rte_dest | input | 16*NUM_PINS | Per-pin destination field, pin p at [16p+15:16p] |
| rte_dest_logical | input | NUM_PINS | Per-pin destination-mode bit |
| msi_valid | output | 1 | Message write offered |
| msi_ready | input | 1 | Receiver accepts the message |
| msi_addr | output | 32 | Message address |
| msi_data | output | 32 | Message data |
| remote_irr_set | output | NUM_PINS | Pulse telling the table to set a pin's remote-IRR flag |

## Verification
An input change needs three registers before it is visible: the sampling register, the pending bit, and the message register in the state machine. The first message therefore appears after the third clock edge. A chained message appears on the edge that accepts the one before it. The `remote_irr_set` pulse, and the change in table state that follows from it, fall in the cycle of acceptance. The bench models these steps register by register, with its own per-pin bit vectors and its own selection loop. It then compares valid, address, data and the pulse vector in the middle of every clock period, after the inputs have settled. Each scenario also counts the messages actually accepted per pin, and checks the count only after enough cycles have passed for every message it expects to be due.

// File: rtl/irq_msi_pkg.sv
`timescale 1ns/1ps
package irq_msi_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } sched_state_t;

    localparam logic [31:0] MSI_BASE_ADDR   = 32'hFEE0_0000;
    localparam int          LEGACY_SRC_LINE = 0;
    localparam int          LEGACY_DST_PIN  = 2;

    function automatic logic [31:0] msi_addr_f(input logic [15:0] dest, input logic dmode);
        return MSI_BASE_ADDR | {12'h000, dest, 4'h0} | {29'h0, dmode, 2'b00};
    endfunction

    function automatic logic [31:0] msi_data_f(input logic [7:0] vec, input logic [2:0] dm,
                                               input logic trig_level);
        return {16'h0000, trig_level, 4'h0, dm, vec};
    endfunction

endpackage

// File: rtl/irq_pin_sampler.sv
`timescale 1ns/1ps
module irq_pin_sampler
    import irq_msi_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] irq_in,
    output logic [NUM_PINS-1:0] lvl_q,
    output logic [NUM_PINS-1:0] prev_q
);

    logic [NUM_PINS-1:0] routed;

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_route
            if (p == LEGACY_SRC_LINE) begin : g_src
                assign routed[p] = 1'b0;
            end else if (p == LEGACY_DST_PIN) begin : g_dst
                assign routed[p] = irq_in[p] | irq_in[LEGACY_SRC_LINE];
            end else begin : g_plain
                assign routed[p] = irq_in[p];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q  <= '0;
            prev_q <= '0;
        end else begin
            lvl_q  <= routed;
            prev_q <= lvl_q;
        end
    end

endmodule

// File: rtl/irq_pend_tracker.sv
`timescale 1ns/1ps
module irq_pend_tracker #(
    parameter int NUM_PINS = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] lvl_q,
    input  logic [NUM_PINS-1:0] prev_q,
    input  logic [NUM_PINS-1:0] level,
    input  logic [NUM_PINS-1:0] mask,
    input  logic [NUM_PINS-1:0] clr_edge,
    output logic [NUM_PINS-1:0] pend_q
);

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pend_q[p] <= 1'b0;
                end else if (level[p]) begin
                    pend_q[p] <= lvl_q[p];
                end else if (lvl_q[p] && !prev_q[p] && !mask[p]) begin
                    pend_q[p] <= 1'b1;
                end else if (clr_edge[p]) begin
                    pend_q[p] <= 1'b0;
                end
            end

            // R6: a masked edge that finds nothing pending leaves nothing pending
            assert_masked_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (!level[p] && mask[p] && !pend_q[p]) |=> !pend_q[p]);
        end
    endgenerate

    // R1: the legacy source line never owns a pending request
    assert_pin0_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q[0]);

endmodule

// File: rtl/irq_msi_sched.sv
`timescale 1ns/1ps
module irq_msi_sched
    import irq_msi_pkg::*;
#(
    parameter  int NUM_PINS = 24,
    localparam int SELW     = $clog2(NUM_PINS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_PINS-1:0]    pend,
    input  logic [NUM_PINS-1:0]    mask,
    input  logic [NUM_PINS-1:0]    level,
    input  logic [NUM_PINS-1:0]    rirr_in,
    input  logic [8*NUM_PINS-1:0]  vec,
    input  logic [3*NUM_PINS-1:0]  dm,
    input  logic [16*NUM_PINS-1:0] dest,
    input  logic [NUM_PINS-1:0]    dmode,
    input  logic                   msi_ready,
    output logic                   msi_valid,
    output logic [31:0]            msi_addr,
    output logic [31:0]            msi_data,
    output logic [NUM_PINS-1:0]    rirr_set,
    output logic [NUM_PINS-1:0]    clr_edge
);

    sched_state_t        state_q, state_d;
    logic [SELW-1:0]     sel_q, pick;
    logic                found, hs, load;
    logic [NUM_PINS-1:0] cand, src;
    logic [31:0]         addr_q, data_q;
    int                  pidx;

    assign hs   = (state_q == ST_ISSUE) && msi_ready;
    assign load = found && ((state_q == ST_IDLE) || hs);
    assign pidx = int'(pick);

    always_comb begin
        cand  = pend & ~mask & ~(level & rirr_in);
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            src[i] = (state_q == ST_IDLE) ? cand[i] : (cand[i] && (i > int'(sel_q)));
        end
        for (int i = NUM_PINS - 1; i >= 0; i--) begin
            if (src[i]) begin
                found = 1'b1;
                pick  = SELW'(i);
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (found) state_d = ST_ISSUE;
            ST_ISSUE: if (hs)    state_d = found ? ST_ISSUE : ST_IDLE;
            default:             state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else if (load) begin
            sel_q  <= pick;
            addr_q <= msi_addr_f(dest[16*pidx +: 16], dmode[pidx]);
            data_q <= msi_data_f(vec[8*pidx +: 8], dm[3*pidx +: 3], level[pidx]);
        end
    end

    always_comb begin
        msi_valid = (state_q == ST_ISSUE);
        msi_addr  = addr_q;
        msi_data  = data_q;
        rirr_set  = '0;
        clr_edge  = '0;
        if (hs) begin
            if (data_q[15]) rirr_set[sel_q] = 1'b1;
            else            clr_edge[sel_q] = 1'b1;
        end
    end

    // R8: an offered message waits unchanged for acceptance
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_valid && !msi_ready) |=> (msi_valid && $stable(msi_addr) && $stable(msi_data)));

    // R7: a chained message always belongs to a higher pin
    assert_ascending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_valid && msi_ready) |=> (!msi_valid || (sel_q > $past(sel_q))));

    // R3: a level message is never offered for a pin whose flag is set
    assert_no_coalesced_send_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_valid && msi_data[15]) |-> !rirr_in[sel_q]);

    // R2: the flag-set pulse only accompanies an accepted write
    assert_rirr_on_send_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|rirr_set) |-> (msi_valid && msi_ready && $onehot0(rirr_set)));

    // R9: fixed address bits
    assert_addr_base_R9: assert property (@(posedge clk) disable iff (!rst_n)
        msi_valid |-> (msi_addr[31:20] == 12'hFEE && msi_addr[3] == 1'b0 && msi_addr[1:0] == 2'b00));

endmodule

// File: rtl/irq_msi_gen.sv
`timescale 1ns/1ps
module irq_msi_gen #(
    parameter int NUM_PINS = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_PINS-1:0]    irq_in,
    input  logic [NUM_PINS-1:0]    rte_mask,
    input  logic [NUM_PINS-1:0]    rte_level,
    input  logic [NUM_PINS-1:0]    rte_remote_irr,
    input  logic [8*NUM_PINS-1:0]  rte_vector,
    input  logic [3*NUM_PINS-1:0]  rte_deliv,
    input  logic [16*NUM_PINS-1:0] rte_dest,
    input  logic [NUM_PINS-1:0]    rte_dest_logical,
    output logic                   msi_valid,
    input  logic                   msi_ready,
    output logic [31:0]            msi_addr,
    output logic [31:0]            msi_data,
    output logic [NUM_PINS-1:0]    remote_irr_set
);

    logic [NUM_PINS-1:0] lvl_q, prev_q, pend_q, clr_edge;

    irq_pin_sampler #(.NUM_PINS(NUM_PINS)) u_sampler (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_in (irq_in),
        .lvl_q  (lvl_q),
        .prev_q (prev_q)
    );

    irq_pend_tracker #(.NUM_PINS(NUM_PINS)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_q    (lvl_q),
        .prev_q   (prev_q),
        .level    (rte_level),
        .mask     (rte_mask),
        .clr_edge (clr_edge),
        .pend_q   (pend_q)
    );

    irq_msi_sched #(.NUM_PINS(NUM_PINS)) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend      (pend_q),
        .mask      (rte_mask),
        .level     (rte_level),
        .rirr_in   (rte_remote_irr),
        .vec       (rte_vector),
        .dm        (rte_deliv),
        .dest      (rte_dest),
        .dmode     (rte_dest_logical),
        .msi_ready (msi_ready),
        .msi_valid (msi_valid),
        .msi_addr  (msi_addr),
        .msi_data  (msi_data),
        .rirr_set  (remote_irr_set),
        .clr_edge  (clr_edge)
    );

endmodule

// File: tb/tb_irq_msi_gen.sv
`timescale 1ns/1ps
module tb_irq_msi_gen;

    localparam int N = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] irq_drv = '0, tb_mask = '0, tb_level = '0, tb_rirr, eoi_clr = '0;
    logic [N-1:0] tb_dmode;
    logic [8*N-1:0] tb_vec;
    logic [3*N-1:0] tb_dm;
    logic [16*N-1:0] tb_dest;
    logic rdy = 1'b1;
    logic msi_valid;
    logic [31:0] msi_addr, msi_data;
    logic [N-1:0] remote_irr_set;

    always #4 clk = ~clk;

    irq_msi_gen #(.NUM_PINS(N)) dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_drv), .rte_mask(tb_mask), .rte_level(tb_level),
        .rte_remote_irr(tb_rirr), .rte_vector(tb_vec), .rte_deliv(tb_dm), .rte_dest(tb_dest),
        .rte_dest_logical(tb_dmode), .msi_valid(msi_valid), .msi_ready(rdy),
        .msi_addr(msi_addr), .msi_data(msi_data), .remote_irr_set(remote_irr_set)
    );

    int n_checks = 0, n_fail = 0, cyc = 0;
    bit done = 1'b0, chk_on = 1'b0;
    string cur_req = "R12";
    int dcount[N];
    int rcount[N];
    int log_pin[$];
    int log_cyc[$];

    function automatic logic [31:0] exp_addr(input int p);
        return 32'hFEE00000 + 32'(p * 273 * 16) + 32'((p % 2) * 4);
    endfunction

    function automatic logic [31:0] exp_data(input int p, input logic lv);
        return (lv ? 32'd32768 : 32'd0) + 32'((p % 8) * 256) + 32'(64 + p);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // behavioural reference
    bit mv;
    int msel;
    logic [31:0] maddr, mdata;
    logic [N-1:0] mlvl, mprev, mpend;

    always @(posedge clk) begin : model
        logic hs;
        logic [N-1:0] cand, np, nr, routed;
        int nxt;
        if (!rst_n) begin
            mv = 1'b0; msel = 0; maddr = '0; mdata = '0;
            mlvl = '0; mprev = '0; mpend = '0;
            tb_rirr <= '0;
        end else begin
            hs = mv && rdy;
            for (int i = 0; i < N; i++)
                cand[i] = mpend[i] && !tb_mask[i] && !(tb_level[i] && tb_rirr[i]);
            for (int i = 0; i < N; i++) begin
                np[i] = mpend[i];
                if (tb_level[i]) np[i] = mlvl[i];
                else begin
                    if (hs && msel == i && !mdata[15]) np[i] = 1'b0;
                    if (mlvl[i] && !mprev[i] && !tb_mask[i]) np[i] = 1'b1;
                end
            end
            nr = tb_rirr & ~eoi_clr;
            if (hs && mdata[15]) nr[msel] = 1'b1;
            tb_rirr <= nr;
            nxt = -1;
            for (int i = N - 1; i >= 0; i--)
                if (cand[i] && (!mv || i > msel)) nxt = i;
            if (!mv || hs) begin
                if (nxt >= 0) begin
                    mv = 1'b1; msel = nxt;
                    maddr = exp_addr(nxt); mdata = exp_data(nxt, tb_level[nxt]);
                end else begin
                    mv = 1'b0;
                end
            end
            routed = irq_drv;
            routed[2] = irq_drv[2] | irq_drv[0];
            routed[0] = 1'b0;
            mpend = np; mprev = mlvl; mlvl = routed;
        end
    end

    always @(negedge clk) begin : cmp
        logic [N-1:0] exp_rs;
        bit ok;
        int v;
        cyc++;
        if (rst_n && chk_on) begin
            exp_rs = '0;
            if (mv && rdy && mdata[15]) exp_rs[msel] = 1'b1;
            ok = (msi_valid === mv) && (remote_irr_set === exp_rs) &&
                 (!mv || (msi_addr === maddr && msi_data === mdata));
            chk(ok, cur_req, "cycle compare valid/addr/data/pulse", msi_data, mdata);
            if (msi_valid && rdy) begin
                v = int'(msi_data[7:0]) - 64;
                if (v >= 0 && v < N) dcount[v]++;
                log_pin.push_back(v);
                log_cyc.push_back(cyc);
            end
            for (int i = 0; i < N; i++) if (remote_irr_set[i]) rcount[i]++;
        end
    end

    task automatic nxt(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    initial begin : watchdog
        #(8 * 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : stim
        int base, base2, l0, lat;
        for (int i = 0; i < N; i++) begin
            tb_vec[8*i +: 8]   = 8'(64 + i);
            tb_dm[3*i +: 3]    = 3'(i % 8);
            tb_dest[16*i +: 16] = 16'(i * 273);
            tb_dmode[i]        = 1'(i % 2);
            dcount[i] = 0; rcount[i] = 0;
        end
        tb_level[9] = 1'b1;
        nxt(3);
        rst_n = 1'b1;
        chk_on = 1'b1;
        nxt(3);
        // R12: quiet after reset
        chk(msi_valid === 1'b0 && remote_irr_set === '0, "R12", "reset outputs",
            {31'd0, msi_valid}, 32'd0);

        // R11 / R5: edge pin 5, latency and single shot while held
        cur_req = "R5";
        base = dcount[5];
        irq_drv[5] = 1'b1;
        lat = 0;
        do begin nxt(1); lat++; end while (!msi_valid && lat < 10);
        chk(lat == 3, "R11", "edges until valid", 32'(lat), 32'd3);
        nxt(10);
        chk(dcount[5] - base == 1, "R5", "held edge deliveries", 32'(dcount[5] - base), 32'd1);
        irq_drv[5] = 1'b0;
        nxt(3);
        irq_drv[5] = 1'b1;
        nxt(6);
        chk(dcount[5] - base == 2, "R5", "second rise deliveries", 32'(dcount[5] - base), 32'd2);
        irq_drv[5] = 1'b0;
        nxt(3);

        // R6: masked edge discarded
        cur_req = "R6";
        base = dcount[6];
        tb_mask[6] = 1'b1;
        irq_drv[6] = 1'b1;
        nxt(3);
        irq_drv[6] = 1'b0;
        nxt(2);
        tb_mask[6] = 1'b0;
        nxt(8);
        chk(dcount[6] == base, "R6", "masked edge deliveries", 32'(dcount[6] - base), 32'd0);
        irq_drv[6] = 1'b1;
        nxt(6);
        chk(dcount[6] - base == 1, "R6", "unmasked rise deliveries", 32'(dcount[6] - base), 32'd1);
        irq_drv[6] = 1'b0;
        nxt(3);

        // R1: legacy line 0 steered to pin 2
        cur_req = "R1";
        base = dcount[2]; base2 = dcount[0];
        irq_drv[0] = 1'b1;
        nxt(6);
        chk(dcount[2] - base == 1, "R1", "pin 2 deliveries from line 0", 32'(dcount[2] - base), 32'd1);
        chk(dcount[0] == base2, "R1", "pin 0 deliveries", 32'(dcount[0] - base2), 32'd0);
        irq_drv[0] = 1'b0;
        nxt(3);

        // R2 / R3 / R4: level pin 9 with remote-IRR coalescing
        cur_req = "R2";
        base = dcount[9]; base2 = rcount[9];
        irq_drv[9] = 1'b1;
        nxt(8);
        chk(dcount[9] - base == 1, "R2", "level deliveries", 32'(dcount[9] - base), 32'd1);
        chk(rcount[9] - base2 == 1, "R2", "flag-set pulses", 32'(rcount[9] - base2), 32'd1);
        cur_req = "R3";
        nxt(10);
        chk(dcount[9] - base == 1, "R3", "coalesced deliveries", 32'(dcount[9] - base), 32'd1);
        eoi_clr[9] = 1'b1;
        nxt(1);
        eoi_clr[9] = 1'b0;
        nxt(6);
        chk(dcount[9] - base == 2, "R3", "redelivery after clear", 32'(dcount[9] - base), 32'd2);
        cur_req = "R4";
        irq_drv[9] = 1'b0;
        nxt(4);
        eoi_clr[9] = 1'b1;
        nxt(1);
        eoi_clr[9] = 1'b0;
        nxt(8);
        chk(dcount[9] - base == 2, "R4", "deliveries after line drop", 32'(dcount[9] - base), 32'd2);

        // R8 / R9 / R10 / R7: stalled burst then ordered drain
        cur_req = "R8";
        rdy = 1'b0;
        irq_drv[12] = 1'b1; irq_drv[3] = 1'b1; irq_drv[7] = 1'b1;
        nxt(8);
        chk(msi_valid === 1'b1, "R8", "valid held while stalled", {31'd0, msi_valid}, 32'd1);
        chk(msi_addr === exp_addr(3), "R9", "address of pin 3", msi_addr, exp_addr(3));
        chk(msi_data === exp_data(3, 1'b0), "R10", "data of pin 3", msi_data, exp_data(3, 1'b0));
        l0 = log_pin.size();
        cur_req = "R7";
        rdy = 1'b1;
        nxt(6);
        chk(log_pin.size() - l0 == 3, "R7", "burst length", 32'(log_pin.size() - l0), 32'd3);
        if (log_pin.size() - l0 == 3) begin
            chk(log_pin[l0] == 3 && log_pin[l0+1] == 7 && log_pin[l0+2] == 12, "R7", "order",
                32'(log_pin[l0+2]), 32'd12);
            chk(log_cyc[l0+1] == log_cyc[l0] + 1 && log_cyc[l0+2] == log_cyc[l0] + 2, "R7",
                "back to back", 32'(log_cyc[l0+2] - log_cyc[l0]), 32'd2);
        end
        irq_drv = '0;
        nxt(4);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule